// File: doc/BRIEF.md
# Serial Memory-Mapped Access Master

This block turns single parallel access requests into framed serial transactions on a four-wire serial bus, clock polarity and phase both zero. It serves a display coprocessor whose registers and memory sit in a 22-bit byte address space. A request names a frame kind, an address, a byte count of one to four and write data. The block sends the address header and moves the data bytes least significant first. For reads it skips one dummy byte before it captures data. It also sends three-byte host command frames that carry no address.

The serial clock rate is set per transaction by a divisor input, which is captured when the request is accepted. Firmware can therefore probe the device at a slow rate and raise the rate once the device has answered. A request is taken in any cycle where the block is idle and `req_valid` is high. `busy` then stays high until the one-cycle `done` pulse, and read data is valid on `rdata` from that pulse onward.

Top module: `spi_mem_master`

## Requirements
- R1: `spi_sclk` is low whenever `spi_cs_n` is high, including after reset. Each byte goes out most significant bit first. `spi_mosi` is set up before each rising clock edge, and `spi_miso` is sampled on the rising edge.
- R2: The kind is decoded from `req_kind`: 2'b00 is a read, 2'b01 is a write, and 2'b10 or 2'b11 is a host command. A read frame opens with three address bytes sent high byte first, and the first byte is {2'b00, addr[21:16]}.
- R3: A write frame opens with three address bytes, the first being 8'h80 OR addr[21:16], followed by addr[15:8] and addr[7:0].
- R4: After a read header, exactly one dummy byte is clocked, and its `spi_miso` value is discarded. The data phase of a read transmits 8'h00 whatever `req_wdata` holds.
- R5: The byte count is `req_len`+1. Data byte k travels as `req_wdata[8k+7:8k]` on writes and lands in `rdata[8k+7:8k]` on reads, with byte 0 first. Bytes of `rdata` beyond the count read zero.
- R6: A host command frame is `req_wdata[7:0]` followed by two 8'h00 bytes, 24 clock cycles in all, with no address phase.
- R7: `spi_cs_n` stays low without a break for the whole frame. Exactly eight rising clock edges occur per frame byte.
- R8: The first rising edge comes `clk_div`+1 system clocks after `spi_cs_n` falls. Every high and low phase of `spi_sclk` lasts `clk_div`+1 system clocks, using the value captured at accept.
- R9: `spi_cs_n` rises `clk_div`+1 system clocks after the last falling edge. It stays high for at least two system clocks before the next fall.
- R10: `busy` is high from the cycle after accept until the cycle `done` pulses. `done` is high for one cycle, and `busy` is low in that cycle.
- R11: A request presented while `busy` is high is ignored. It starts no frame and does not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_kind | input | 2 | 00 read, 01 write, 1x host command |
| req_addr | input | 22 | Byte address |
| req_len | input | LEN_W (2) | Byte count minus one |
| req_wdata | input | DATA_W (32) | Write data, or command byte in [7:0] |
| clk_div | input | DIV_W (8) | Serial half-period in system clocks, minus one |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W (32) | Read data, byte 0 in the low bits |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume that `rst_n` is held low for at least two clocks at start-up. They also assume that the request fields and `clk_div` only need to be valid in the cycle a request is accepted. The stimulus drives every request input on the falling system clock edge, so the values are settled at the accepting edge. The device model changes `spi_miso` only on falling serial clock edges and at chip-select fall. `req_len` and `req_kind` are kept to the encodings stated in the requirements.

// File: rtl/spim_pkg.sv
// Shared types and constants for the serial memory-access master.
// Assumes a 22-bit byte address space carried in a 24-bit header.
package spim_pkg;

    localparam int ADDR_W = 22;
    localparam int HDR_BYTES = 3;
    localparam logic [7:0] WRITE_FLAG = 8'h80;

    typedef enum logic [1:0] {
        FR_READ  = 2'd0,
        FR_WRITE = 2'd1,
        FR_CMD   = 2'd2
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } seq_state_e;

    // Maps the request kind code onto a frame type.
    function automatic frame_e decode_kind(input logic [1:0] code);
        if (code[1])
            return FR_CMD;
        else if (code[0])
            return FR_WRITE;
        else
            return FR_READ;
    endfunction

endpackage

// File: rtl/spim_divider.sv
// Half-period timer for the serial clock.
// Emits a one-cycle tick every div+1 clocks while run is high.
// Assumes div is held constant while run is high.
module spim_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R8: the half-period counter never passes the divisor.
    a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div));

endmodule

// File: rtl/spim_byte_mux.sv
// Frame layout logic: selects the byte to transmit at a given position and
// flags the current position as last byte or as captured read data.
// Assumes the frame fields are held constant during a transaction.
module spim_byte_mux
    import spim_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int IDX_W      = 4,
    parameter int LEN_W      = 2
) (
    input  frame_e                    kind,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LEN_W-1:0]          len,
    input  logic [8*DATA_BYTES-1:0]   wdata,
    input  logic [IDX_W-1:0]          cur_idx,
    input  logic [IDX_W-1:0]          tx_idx,
    output logic [7:0]                tx_byte,
    output logic                      last,
    output logic                      rx_data,
    output logic [IDX_W-1:0]          rx_slot
);

    logic [IDX_W-1:0] body_start;
    logic [IDX_W-1:0] count;
    logic [IDX_W-1:0] tx_slot;

    // Frame length and data-phase start for the current kind.
    always_comb begin
        body_start = (kind == FR_READ) ? IDX_W'(HDR_BYTES + 1) : IDX_W'(HDR_BYTES);
        if (kind == FR_CMD)
            count = IDX_W'(HDR_BYTES);
        else
            count = body_start + IDX_W'(len) + IDX_W'(1);
        rx_slot = cur_idx - body_start;
        tx_slot = tx_idx - body_start;
        last    = (cur_idx == count - IDX_W'(1));
        rx_data = (kind == FR_READ) && (cur_idx >= body_start);
    end

    // Byte to send at position tx_idx.
    always_comb begin
        tx_byte = 8'h00;
        if (kind == FR_CMD) begin
            if (tx_idx == '0)
                tx_byte = wdata[7:0];
        end else if (tx_idx == IDX_W'(0)) begin
            tx_byte = {2'b00, addr[21:16]};
            if (kind == FR_WRITE)
                tx_byte = tx_byte | WRITE_FLAG;
        end else if (tx_idx == IDX_W'(1)) begin
            tx_byte = addr[15:8];
        end else if (tx_idx == IDX_W'(2)) begin
            tx_byte = addr[7:0];
        end else if (kind == FR_WRITE) begin
            for (int k = 0; k < DATA_BYTES; k++) begin
                if (tx_slot == IDX_W'(k))
                    tx_byte = wdata[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/spim_shifter.sv
// Bit shifter for one serial byte in each direction, most significant bit
// first. Assumes load and shift are never requested together.
module spim_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    input  logic       sample,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte
);

    logic [7:0] tx_q;
    logic [7:0] rx_q;

    // Hold the outgoing byte and move to the next bit on a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_byte;
        else if (shift)
            tx_q <= {tx_q[6:0], 1'b0};
    end

    // Collect incoming bits on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_q <= '0;
        else if (sample)
            rx_q <= {rx_q[6:0], miso};
    end

    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;

    // R1: a byte is never reloaded and shifted in the same cycle.
    a_r1_load_or_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/spi_mem_master.sv
// Serial memory-access master, clock mode 0. Frames reads, writes and
// host commands, paces the serial clock from a divisor and gathers
// little-endian read data. Assumes request fields are valid in the
// accepting cycle only; they are captured there.
module spi_mem_master
    import spim_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int DIV_W      = 8,
    parameter int MIN_GAP    = 2,
    localparam int DATA_W    = 8 * DATA_BYTES,
    localparam int LEN_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int IDX_W = $clog2(DATA_BYTES + HDR_BYTES + 2);
    localparam int GAP_W = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;

    seq_state_e        state;
    frame_e            kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rdata_q;
    logic [IDX_W-1:0]  byte_idx;
    logic [IDX_W-1:0]  tx_idx;
    logic [2:0]        bit_idx;
    logic [GAP_W-1:0]  gap_cnt;
    logic              sclk_q;
    logic              cs_n_q;
    logic              done_q;

    logic              accept;
    logic              run;
    logic              tick;
    logic              byte_end;
    logic              fall;
    logic              last;
    logic              rx_data;
    logic [IDX_W-1:0]  rx_slot;
    logic [7:0]        tx_byte;
    logic [7:0]        rx_byte;
    logic              sh_load;
    logic              sh_shift;
    logic              sh_sample;

    // Derived strobes for this cycle.
    always_comb begin
        accept    = (state == ST_IDLE) && req_valid;
        run       = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
        byte_end  = (bit_idx == 3'd7);
        fall      = (state == ST_HIGH) && tick;
        tx_idx    = (state == ST_LOAD) ? '0 : byte_idx + IDX_W'(1);
        sh_load   = (state == ST_LOAD) || (fall && byte_end && !last);
        sh_shift  = fall && !byte_end;
        sh_sample = (state == ST_LOW) && tick;
    end

    spim_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    spim_byte_mux #(
        .DATA_BYTES (DATA_BYTES),
        .IDX_W      (IDX_W),
        .LEN_W      (LEN_W)
    ) u_mux (
        .kind    (kind_q),
        .addr    (addr_q),
        .len     (len_q),
        .wdata   (wdata_q),
        .cur_idx (byte_idx),
        .tx_idx  (tx_idx),
        .tx_byte (tx_byte),
        .last    (last),
        .rx_data (rx_data),
        .rx_slot (rx_slot)
    );

    spim_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_byte (tx_byte),
        .shift     (sh_shift),
        .sample    (sh_sample),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte)
    );

    // Sequence the frame: select, clock phases, release and idle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            bit_idx  <= '0;
            byte_idx <= '0;
            gap_cnt  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        bit_idx  <= '0;
                        byte_idx <= '0;
                        state    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cs_n_q <= 1'b0;
                    state  <= ST_LOW;
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        state  <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_q  <= 1'b0;
                        bit_idx <= bit_idx + 3'd1;
                        if (byte_end && last) begin
                            state <= ST_TAIL;
                        end else begin
                            if (byte_end)
                                byte_idx <= byte_idx + IDX_W'(1);
                            state <= ST_LOW;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_n_q  <= 1'b1;
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(MIN_GAP - 1)) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture request fields at accept; they stay fixed until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= FR_READ;
            addr_q  <= '0;
            len_q   <= '0;
            wdata_q <= '0;
            div_q   <= '0;
        end else if (accept) begin
            kind_q  <= decode_kind(req_kind);
            addr_q  <= req_addr;
            len_q   <= req_len;
            wdata_q <= req_wdata;
            div_q   <= clk_div;
        end
    end

    // Place each completed read data byte into its little-endian lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= '0;
        end else if (fall && byte_end && rx_data) begin
            for (int k = 0; k < DATA_BYTES; k++) begin
                if (rx_slot == IDX_W'(k))
                    rdata_q[8*k +: 8] <= rx_byte;
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign rdata    = rdata_q;
    assign spi_sclk = sclk_q;
    assign spi_cs_n = cs_n_q;

    // R1: the serial clock rests low while the device is deselected.
    a_r1_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R7: select is held low in every clocking phase.
    a_r7_cs_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW || state == ST_HIGH || state == ST_TAIL) |-> !spi_cs_n);

    // R8: the serial clock only moves after a half-period tick.
    a_r8_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_sclk) |-> $past(tick));

    // R9: select was high for at least two clocks before it falls.
    a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> ($past(spi_cs_n) && $past(spi_cs_n, 2)));

    // R10: done lasts one cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy only drops together with done.
    a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11: captured request fields do not change while busy.
    a_r11_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(wdata_q) && $stable(len_q) && $stable(div_q)));

endmodule

// File: tb/spi_mem_master_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, busy-time requests and back-to-back frames.
module spi_mem_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  clk_div = '0;
    logic        busy;
    logic        done;
    logic [31:0] rdata;
    logic        spi_sclk;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    spi_mem_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_wdata (req_wdata),
        .clk_div   (clk_div),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    // kind, len, addr, wdata, div, device read data
    localparam logic [97:0] VECS [9] = '{
        {2'b00, 2'd0, 22'h0C0000, 32'h00000000, 8'd3, 32'h1122337C},
        {2'b01, 2'd1, 22'h102468, 32'h0000BEEF, 8'd1, 32'h00000000},
        {2'b01, 2'd3, 22'h3FFFFC, 32'hDEADBEEF, 8'd0, 32'h00000000},
        {2'b00, 2'd3, 22'h3FFFFF, 32'h00000000, 8'd0, 32'hCAFEF00D},
        {2'b10, 2'd0, 22'h155555, 32'h00000068, 8'd2, 32'h00000000},
        {2'b00, 2'd1, 22'h000001, 32'hFFFFFFFF, 8'd2, 32'h8001A55A},
        {2'b11, 2'd3, 22'h2AAAAA, 32'h12345600, 8'd0, 32'h00000000},
        {2'b01, 2'd0, 22'h000000, 32'hFFFFFF5A, 8'd5, 32'h00000000},
        {2'b00, 2'd2, 22'h2D0F1E, 32'h00000000, 8'd1, 32'h77665544}
    };

    // Device model state.
    logic [63:0] miso_stream = '0;
    logic [63:0] cap = '0;
    int  rise_cnt = 0;
    int  cs_falls = 0;
    int  cs_rises_in_frame = 0;
    int  stray_edges = 0;
    int  bad_cs_edges = 0;
    int  hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
    int  lead_cyc = 0, tail_cyc = 0, gap_cyc = 0;
    time t_csfall = 0, t_csrise = 0, t_rise = 0, t_fall = 0;

    // Chip select falls: start a new frame capture.
    always @(negedge spi_cs_n) begin
        if (spi_sclk !== 1'b0) bad_cs_edges++;
        gap_cyc = int'(($time - t_csrise) / 10);
        t_csfall = $time;
        rise_cnt = 0;
        cap = '0;
        cs_rises_in_frame = 0;
        hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
        cs_falls++;
        spi_miso = miso_stream[63];
    end

    // Chip select rises: record the release delay.
    always @(posedge spi_cs_n) begin
        if (spi_sclk !== 1'b0) bad_cs_edges++;
        tail_cyc = int'(($time - t_fall) / 10);
        t_csrise = $time;
        cs_rises_in_frame++;
    end

    // Rising serial edge: capture MOSI and time the low phase.
    always @(posedge spi_sclk) begin
        int d;
        if (spi_cs_n) stray_edges++;
        if (rise_cnt == 0) begin
            lead_cyc = int'(($time - t_csfall) / 10);
        end else begin
            d = int'(($time - t_fall) / 10);
            if (d < lo_min) lo_min = d;
            if (d > lo_max) lo_max = d;
        end
        cap = {cap[62:0], spi_mosi};
        rise_cnt++;
        t_rise = $time;
    end

    // Falling serial edge: present the next MISO bit, time the high phase.
    always @(negedge spi_sclk) begin
        int d;
        d = int'(($time - t_rise) / 10);
        if (d < hi_min) hi_min = d;
        if (d > hi_max) hi_max = d;
        t_fall = $time;
        if (rise_cnt < 64) spi_miso = miso_stream[63 - rise_cnt];
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected frame bytes, first byte in the most significant position.
    function automatic logic [63:0] exp_frame(input logic [1:0] k, input logic [21:0] a,
                                              input int nb, input logic [31:0] wd,
                                              output int nbytes);
        logic [7:0]  b [8];
        logic [63:0] r;
        for (int i = 0; i < 8; i++) b[i] = 8'h00;
        if (k[1]) begin
            b[0] = wd[7:0];
            nbytes = 3;
        end else begin
            b[0] = {k[0], 1'b0, a[21:16]};
            b[1] = a[15:8];
            b[2] = a[7:0];
            if (k[0]) begin
                for (int i = 0; i < nb; i++) b[3 + i] = wd[8*i +: 8];
                nbytes = 3 + nb;
            end else begin
                nbytes = 4 + nb;
            end
        end
        r = '0;
        for (int i = 0; i < nbytes; i++) r = {r[55:0], b[i]};
        return r;
    endfunction

    task automatic drive_req(input logic [1:0] k, input logic [1:0] ln, input logic [21:0] a,
                             input logic [31:0] wd, input logic [7:0] dv);
        req_kind = k; req_len = ln; req_addr = a; req_wdata = wd; clk_div = dv;
        req_valid = 1'b1;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (done !== 1'b1 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_txn(input logic [1:0] k, input logic [1:0] ln, input logic [21:0] a,
                           input logic [31:0] wd, input logic [7:0] dv, input logic [31:0] md);
        int nb;
        int nbytes;
        int cyc;
        logic [63:0] ef;
        logic [31:0] er;
        nb = int'(ln) + 1;
        ef = exp_frame(k, a, nb, wd, nbytes);
        miso_stream = {32'hA5A5A5A5, md[7:0], md[15:8], md[23:16], md[31:24]};
        @(negedge clk);
        drive_req(k, ln, a, wd, dv);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1 && done === 1'b0, "R10 busy after accept", {busy, done}, 2'b10);
        wait_done(cyc);
        check(done === 1'b1, "R10 done reached", done, 1);
        check(busy === 1'b0, "R10 busy low with done", busy, 0);
        if (k[1])
            check(cap === ef, "R6 command frame", cap, ef);
        else if (k[0])
            check(cap === ef, "R3 write header and data", cap, ef);
        else
            check(cap === ef, "R2 and R4 read header, dummy, zero data", cap, ef);
        check(rise_cnt == 8 * nbytes, "R7 rising edges per frame", rise_cnt, 8 * nbytes);
        check(cs_rises_in_frame == 1, "R7 select unbroken", cs_rises_in_frame, 1);
        check(lead_cyc == int'(dv) + 1, "R8 lead time", lead_cyc, int'(dv) + 1);
        check(hi_min == int'(dv) + 1 && hi_max == int'(dv) + 1, "R8 high phase",
              {hi_min[31:0], hi_max[31:0]}, int'(dv) + 1);
        check(lo_min == int'(dv) + 1 && lo_max == int'(dv) + 1, "R8 low phase",
              {lo_min[31:0], lo_max[31:0]}, int'(dv) + 1);
        check(tail_cyc == int'(dv) + 1, "R9 select release delay", tail_cyc, int'(dv) + 1);
        if (!k[1] && !k[0]) begin
            er = (nb == 4) ? md : (md & ((32'h1 << (8 * nb)) - 32'h1));
            check(rdata === er, "R5 little-endian read data", rdata, er);
        end
        @(negedge clk);
        check(done === 1'b0, "R10 done single cycle", done, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        int falls0;
        logic [63:0] ef;
        int nbytes;
        logic [97:0] v;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R10: reset state
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 idle bus after reset",
              {spi_cs_n, spi_sclk}, 2'b10);
        check(busy === 1'b0 && done === 1'b0, "R10 idle after reset", {busy, done}, 2'b00);

        for (int i = 0; i < 9; i++) begin
            v = VECS[i];
            run_txn(v[97:96], v[95:94], v[93:72], v[71:40], v[39:32], v[31:0]);
        end

        // R11: requests during busy are ignored.
        ef = exp_frame(2'b00, 22'h000100, 4, 32'h0, nbytes);
        miso_stream = {32'hA5A5A5A5, 8'hFE, 8'hCA, 8'hAD, 8'h0B};
        falls0 = cs_falls;
        @(negedge clk);
        drive_req(2'b00, 2'd3, 22'h000100, 32'h0, 8'd2);
        @(negedge clk);
        drive_req(2'b01, 2'd3, 22'h3ABCDE, 32'h55AA55AA, 8'd0);
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        wait_done(cyc);
        check(cap === ef, "R11 frame unchanged by busy request", cap, ef);
        check(rdata === 32'h0BADCAFE, "R11 read data intact", rdata, 32'h0BADCAFE);
        repeat (30) @(negedge clk);
        check(cs_falls == falls0 + 1, "R11 no extra frame started", cs_falls, falls0 + 1);
        check(spi_cs_n === 1'b1 && busy === 1'b0, "R11 idle after ignored request",
              {spi_cs_n, busy}, 2'b10);

        // R9: back-to-back requests keep a select high gap.
        falls0 = cs_falls;
        miso_stream = '0;
        @(negedge clk);
        drive_req(2'b01, 2'd0, 22'h001234, 32'h000000C3, 8'd0);
        wait_done(cyc);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(cyc);
        check(cs_falls == falls0 + 2, "R9 two frames issued", cs_falls, falls0 + 2);
        check(gap_cyc >= 2, "R9 minimum select high time", gap_cyc, 2);

        // R1: reset in the middle of a frame returns the bus to idle.
        @(negedge clk);
        drive_req(2'b00, 2'd3, 22'h0ABCDE, 32'h0, 8'd3);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && busy === 1'b0,
              "R1 bus idle under reset", {spi_cs_n, spi_sclk, busy}, 3'b100);
        rst_n = 1'b1;
        run_txn(2'b00, 2'd1, 22'h0C0000, 32'h0, 8'd1, 32'h0000C07C);

        check(stray_edges == 0, "R1 no clock edge while deselected", stray_edges, 0);
        check(bad_cs_edges == 0, "R1 clock low at select edges", bad_cs_edges, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule